// File: doc/BRIEF.md
# Compact Float Immediate Loader

This block runs two immediate-load operations that target a 64-bit double-precision floating-point register. The upper-half load takes a 16-bit immediate from the instruction word and places it in the top half of a single-precision pattern, with the low half set to zero. In effect it reads the immediate as a brain-float value. It then widens that pattern to double precision and returns it as the new register value.

The lower-half patch is a read-modify-write. It narrows the current register contents to single precision and overwrites the low 16 bits of that single-precision pattern with the immediate. It then widens the result back to double precision. Issuing an upper-half load and then a lower-half patch to the same register builds any exact single-precision constant without a memory access.

The surrounding pipeline supplies the instruction word, an operation select, a valid strobe and the current contents of the target register. The block returns a registered result, the target register index and a one-cycle write strobe for the register file. Neither operation has a status or exception output of any kind.

Top module: `flt_imm_loader`

## Requirements
- R1: Instruction bits are numbered MSB-first, so bit k is `instrWord[31-k]`. The target index is `instrWord[25:21]`. The immediate is `{instrWord[15:6], instrWord[20:16], instrWord[0]}`, with its MSB first. All other instruction bits are ignored.
- R2: `opSel` = 0 selects the upper-half load and `opSel` = 1 selects the lower-half patch. The upper-half load ignores `curValue`.
- R3: The upper-half load forms the single-precision pattern `{imm, 16'h0000}` and widens it. A normal input keeps its sign, adds 896 to its exponent and places its 23 fraction bits at the top of the 52-bit fraction. Examples: 0x3F80 gives 0x3FF0000000000000, 0xBFC0 gives 0xBFF8000000000000, and 0x3FFF gives 0x3FFFE00000000000.
- R4: Widening maps a zero to a zero of the same sign (0x8000 gives 0x8000000000000000). Exponent 0xFF maps to 0x7FF with the fraction kept. So 0x7F80 gives 0x7FF0000000000000, 0xFF80 gives 0xFFF0000000000000, and 0x7FC0 gives the quiet NaN 0x7FF8000000000000.
- R5: A single-precision subnormal is normalized while it is widened. If its highest set fraction bit is p, the double exponent is 874+p and the bits below the leading one become the fraction. Examples: 0x0040 gives 0x3800000000000000, and a patch of 0x0001 onto +0.0 gives 0x36A0000000000000.
- R6: The lower-half patch narrows `curValue`, replaces single-precision bits 15:0 with the immediate, and widens the result. An upper-half load of 0x3F80 followed by a patch of 0x8000 on the same register gives 0x3FF0100000000000.
- R7: Narrowing rules, where e is the double exponent and the single-precision fraction is `curValue[51:29]`:
  - e = 0x7FF becomes 0xFF with that fraction.
  - e = 0 becomes a signed zero.
  - e from 897 to 1150 becomes e-896.
  - e above 1150 becomes a signed infinity.
  - e from 874 to 896 becomes a subnormal, `{1, fraction} >> (897-e)`.
  - e below 874 becomes a signed zero.
- R8: The result and index appear on the first rising edge after a valid input, together with a one-cycle `outWrite` pulse. With no valid input, `outWrite` stays low and `outValue` and `outIndex` hold.
- R9: While `rstN` is low, `outValue`, `outIndex` and `outWrite` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operation present this cycle |
| opSel | input | 1 | 0 upper-half load, 1 lower-half patch |
| instrWord | input | 32 | Instruction word carrying index and immediate |
| curValue | input | 64 | Current contents of the target register |
| outValue | output | 64 | Registered double-precision result |
| outIndex | output | 5 | Registered target register index |
| outWrite | output | 1 | One-cycle register-file write strobe |

## Verification
The write-back of one operation and the acceptance of the next one can fall in the same cycle. This happens when operations are issued back to back, and it matters most when a patch targets the register that was loaded one cycle earlier. The bench keeps its own model of a register file over a few registers, so index collisions are frequent. In each cycle, at the falling edge, it checks the previous result against its model and supplies the freshly modelled value as `curValue` for the next operation. Any loss or mixing of consecutive results therefore shows up as a mismatch.

// File: rtl/flt_imm_pkg.sv
package flt_imm_pkg;
  localparam int WORD_W   = 32;
  localparam int DBL_W    = 64;
  localparam int SGL_W    = 32;
  localparam int IMM_W    = 16;
  localparam int IDX_W    = 5;
  localparam int SGL_FR_W = 23;
  localparam int DBL_EX_W = 11;
  localparam int PAD_W    = 52 - SGL_FR_W;
  localparam logic [DBL_EX_W-1:0] BIAS_GAP  = 11'd896;
  localparam logic [DBL_EX_W-1:0] SUB_BASE  = 11'd874;
  localparam logic [DBL_EX_W-1:0] NORM_LOW  = 11'd897;
  localparam logic [DBL_EX_W-1:0] NORM_HIGH = 11'd1150;

  typedef struct packed {
    logic capture;
    logic patchLow;
  } ctrlStrobes_t;
endpackage

// File: rtl/flt_imm_ctrl.sv
module flt_imm_ctrl
  import flt_imm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         opSel,
  output ctrlStrobes_t strobes,
  output logic         writeQ
);
  always_comb begin
    strobes.capture  = inValid;
    strobes.patchLow = inValid & opSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) writeQ <= 1'b0;
    else       writeQ <= inValid;
  end
endmodule

// File: rtl/flt_imm_datapath.sv
module flt_imm_datapath
  import flt_imm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [WORD_W-1:0]  instrWord,
  input  logic [DBL_W-1:0]   curValue,
  output logic [DBL_W-1:0]   resultQ,
  output logic [IDX_W-1:0]   indexQ
);
  logic [IMM_W-1:0] immField;
  logic [IDX_W-1:0] idxField;
  logic [SGL_W-1:0] narrowed;
  logic [SGL_W-1:0] spPattern;
  logic [DBL_W-1:0] widened;

  function automatic logic [DBL_W-1:0] widenSp(input logic [SGL_W-1:0] sp);
    logic                 sgn;
    logic [7:0]           ex;
    logic [SGL_FR_W-1:0]  fr;
    logic [SGL_FR_W-1:0]  norm;
    logic [4:0]           lead;
    logic [DBL_W-1:0]     r;
    sgn  = sp[31];
    ex   = sp[30:23];
    fr   = sp[22:0];
    lead = '0;
    for (int i = 0; i < SGL_FR_W; i++) begin
      if (fr[i]) lead = 5'(i);
    end
    norm = fr << (5'd23 - lead);
    if (ex == 8'hFF)      r = {sgn, 11'h7FF, fr, {PAD_W{1'b0}}};
    else if (ex != 8'h00) r = {sgn, DBL_EX_W'(ex) + BIAS_GAP, fr, {PAD_W{1'b0}}};
    else if (fr == '0)    r = {sgn, 63'b0};
    else                  r = {sgn, SUB_BASE + DBL_EX_W'(lead), norm, {PAD_W{1'b0}}};
    return r;
  endfunction

  function automatic logic [SGL_W-1:0] narrowDp(input logic [DBL_W-1:0] dp);
    logic                 sgn;
    logic [DBL_EX_W-1:0]  ex;
    logic [SGL_FR_W-1:0]  fr;
    logic [DBL_EX_W-1:0]  sh;
    logic [SGL_FR_W:0]    full;
    logic [SGL_W-1:0]     r;
    sgn  = dp[63];
    ex   = dp[62:52];
    fr   = dp[51:29];
    sh   = NORM_LOW - ex;
    full = {1'b1, fr} >> sh;
    if (ex == 11'h7FF)     r = {sgn, 8'hFF, fr};
    else if (ex == '0)     r = {sgn, 31'b0};
    else if (ex > NORM_HIGH) r = {sgn, 8'hFF, 23'b0};
    else if (ex >= NORM_LOW) r = {sgn, 8'(ex - BIAS_GAP), fr};
    else if (ex >= SUB_BASE) r = {sgn, 8'h00, full[SGL_FR_W-1:0]};
    else                   r = {sgn, 31'b0};
    return r;
  endfunction

  always_comb begin
    immField  = {instrWord[15:6], instrWord[20:16], instrWord[0]};
    idxField  = instrWord[25:21];
    narrowed  = narrowDp(curValue);
    spPattern = strobes.patchLow ? {narrowed[31:16], immField}
                                 : {immField, 16'h0000};
    widened   = widenSp(spPattern);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      indexQ  <= '0;
    end else if (strobes.capture) begin
      resultQ <= widened;
      indexQ  <= idxField;
    end
  end
endmodule

// File: rtl/flt_imm_loader.sv
module flt_imm_loader
  import flt_imm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        opSel,
  input  logic [31:0] instrWord,
  input  logic [63:0] curValue,
  output logic [63:0] outValue,
  output logic [4:0]  outIndex,
  output logic        outWrite
);
  ctrlStrobes_t strobes;

  flt_imm_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .opSel   (opSel),
    .strobes (strobes),
    .writeQ  (outWrite)
  );

  flt_imm_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .instrWord (instrWord),
    .curValue  (curValue),
    .resultQ   (outValue),
    .indexQ    (outIndex)
  );
endmodule

// File: rtl/flt_imm_loader_chk.sv
module flt_imm_loader_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        opSel,
  input logic [31:0] instrWord,
  input logic [63:0] curValue,
  input logic [63:0] outValue,
  input logic [4:0]  outIndex,
  input logic        outWrite
);
  a_r8_write_follows_valid: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outWrite);

  a_r8_no_spurious_write: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outWrite);

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outValue) && $stable(outIndex)));

  a_r1_index_routed: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outIndex == $past(instrWord[25:21]));

  a_r3_load_sign_kept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opSel) |=> outValue[63] == $past(instrWord[15]));

  a_r6_patch_sign_kept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel) |=> outValue[63] == $past(curValue[63]));

  a_r5_low_fraction_clear: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValue[28:0] == 29'b0);

  always @(posedge clk) begin
    if (!rstN) begin
      a_r9_reset_quiet: assert (!outWrite || $isunknown(outWrite));
    end
  end
endmodule

bind flt_imm_loader flt_imm_loader_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .opSel     (opSel),
  .instrWord (instrWord),
  .curValue  (curValue),
  .outValue  (outValue),
  .outIndex  (outIndex),
  .outWrite  (outWrite)
);

// File: tb/sim_flt_imm_loader.sv
`timescale 1ns/1ps
module sim_flt_imm_loader;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        opSel = 1'b0;
  logic [31:0] instrWord = '0;
  logic [63:0] curValue = '0;
  logic [63:0] outValue;
  logic [4:0]  outIndex;
  logic        outWrite;

  int nCmp = 0;
  int nBad = 0;
  logic [63:0] regs [0:31];
  logic        done = 1'b0;

  always #10 clk = ~clk;

  flt_imm_loader u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .instrWord(instrWord), .curValue(curValue),
    .outValue(outValue), .outIndex(outIndex), .outWrite(outWrite)
  );

  function automatic logic [63:0] mWiden(input logic [31:0] sp);
    int de;
    logic [23:0] m;
    if (sp[30:0] == 31'b0) return {sp[31], 63'b0};
    if (sp[30:23] == 8'hFF) return {sp[31], 11'h7FF, sp[22:0], 29'b0};
    if (sp[30:23] != 8'h00) begin
      de = int'(sp[30:23]) + 896;
      return {sp[31], 11'(de), sp[22:0], 29'b0};
    end
    m  = {1'b0, sp[22:0]};
    de = 897;
    while (!m[23]) begin
      m  = m << 1;
      de = de - 1;
    end
    return {sp[31], 11'(de), m[22:0], 29'b0};
  endfunction

  function automatic logic [31:0] mNarrow(input logic [63:0] dp);
    int de;
    int sh;
    logic [23:0] m;
    de = int'(dp[62:52]);
    if (de == 2047) return {dp[63], 8'hFF, dp[51:29]};
    if (de == 0)    return {dp[63], 31'b0};
    if (de > 1150)  return {dp[63], 8'hFF, 23'b0};
    if (de >= 897)  return {dp[63], 8'(de - 896), dp[51:29]};
    sh = 897 - de;
    if (sh > 23)    return {dp[63], 31'b0};
    m = {1'b1, dp[51:29]} >> sh;
    return {dp[63], 8'h00, m[22:0]};
  endfunction

  function automatic logic [31:0] mkInstr(input logic [4:0] idx, input logic [15:0] imm,
                                          input logic [31:0] junk);
    logic [31:0] w;
    w = junk;
    w[25:21] = idx;
    w[15:6]  = imm[15:6];
    w[20:16] = imm[5:1];
    w[0]     = imm[0];
    return w;
  endfunction

  function automatic logic [63:0] mResult(input logic op, input logic [15:0] imm,
                                          input logic [63:0] cur);
    logic [31:0] n;
    if (!op) return mWiden({imm, 16'h0});
    n = mNarrow(cur);
    return mWiden({n[31:16], imm});
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [63:0] pendExp;
  logic [4:0]  pendIdx;

  // drive at negedge; result is registered at the following posedge
  task automatic issue(input logic op, input logic [4:0] idx, input logic [15:0] imm);
    opSel     = op;
    instrWord = mkInstr(idx, imm, $urandom);
    curValue  = regs[idx];
    inValid   = 1'b1;
    pendExp   = mResult(op, imm, regs[idx]);
    pendIdx   = idx;
    regs[idx] = pendExp;
  endtask

  task automatic single(input string req, input logic op, input logic [4:0] idx,
                        input logic [15:0] imm, input logic [63:0] lit);
    issue(op, idx, imm);
    @(negedge clk);
    inValid = 1'b0;
    check(req, outValue, lit);
    check("R8 model", outValue, pendExp);
    check("R1 index", {59'b0, outIndex}, {59'b0, idx});
    check("R8 write pulse", {63'b0, outWrite}, 64'd1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) regs[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    check("R9 reset value", outValue, 64'h0);
    check("R9 reset write", {63'b0, outWrite}, 64'd0);
    check("R9 reset index", {59'b0, outIndex}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    single("R4 pos zero",  1'b0, 5'd3, 16'h0000, 64'h0000000000000000);
    single("R4 neg zero",  1'b0, 5'd3, 16'h8000, 64'h8000000000000000);
    single("R3 one",       1'b0, 5'd4, 16'h3F80, 64'h3FF0000000000000);
    single("R6 patch",     1'b1, 5'd4, 16'h8000, 64'h3FF0100000000000);
    single("R3 neg 1.5",   1'b0, 5'd5, 16'hBFC0, 64'hBFF8000000000000);
    single("R3 1.99",      1'b0, 5'd5, 16'h3FFF, 64'h3FFFE00000000000);
    single("R4 pos inf",   1'b0, 5'd6, 16'h7F80, 64'h7FF0000000000000);
    single("R4 neg inf",   1'b0, 5'd6, 16'hFF80, 64'hFFF0000000000000);
    single("R4 qnan",      1'b0, 5'd6, 16'h7FC0, 64'h7FF8000000000000);
    single("R5 subnormal", 1'b0, 5'd7, 16'h0040, 64'h3800000000000000);
    single("R2 load ignores cur", 1'b0, 5'd8, 16'h3F80, 64'h3FF0000000000000);
    single("R5 zero base", 1'b0, 5'd9, 16'h0000, 64'h0);
    single("R5 patch sub", 1'b1, 5'd9, 16'h0001, 64'h36A0000000000000);

    // R8: idle cycles keep outputs
    repeat (2) @(negedge clk);
    check("R8 idle write", {63'b0, outWrite}, 64'd0);
    check("R8 idle hold",  outValue, 64'h36A0000000000000);

    // R7 narrowing edges via patch on seeded registers
    regs[10] = 64'h7FF0000000000001;
    single("R7 nan low bits", 1'b1, 5'd10, 16'h1234, mResult(1'b1, 16'h1234, 64'h7FF0000000000001));
    regs[11] = 64'h47F0000000000000;
    single("R7 overflow", 1'b1, 5'd11, 16'h0000, 64'h7FF0000000000000);
    regs[12] = 64'h3690000000000000;
    single("R7 underflow", 1'b1, 5'd12, 16'h0000, 64'h0);

    // R6/R8: back-to-back random ops over few registers
    for (int k = 0; k < 3000; k++) begin
      logic op;
      logic [4:0] idx;
      logic [15:0] imm;
      op  = 1'($urandom);
      idx = 5'($urandom % 4);
      imm = 16'($urandom);
      if (k % 97 == 0) regs[idx] = {$urandom, $urandom};
      issue(op, idx, imm);
      @(negedge clk);
      check("R6 back-to-back value", outValue, pendExp);
      check("R1 back-to-back index", {59'b0, outIndex}, {59'b0, pendIdx});
      if (!outWrite) check("R8 back-to-back write", 64'd0, 64'd1);
    end
    inValid = 1'b0;
    @(negedge clk);
    check("R8 final idle", {63'b0, outWrite}, 64'd0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        nCmp++;
        nBad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule